// File: doc/BRIEF.md
# Logical Device Activation and Range-Check Register Set

This block is the per-function register file of one logical device on a plug-and-play expansion card. The card's control logic forwards indexed configuration reads and writes to it. The block stores an activate flag, a conflict-test control, eight I/O base addresses, two interrupt entries and two DMA channel selections. Reserved bits always read back as zero.

The block also watches host I/O reads. Each non-zero I/O base opens a window of eight consecutive ports. The conflict test is armed while the device is inactive and the test-enable bit is set. During the test, a host read that lands in any window is answered with a fixed pattern. Firmware uses this answer to detect address clashes before it activates the device. A synchronous configuration reset puts every register back to its power-up value.

Top module: `ldev_cfg_regs`

## Requirements
- R1: After rst_n the registers read back as follows: activate 0x00, range-check 0x00, all I/O base bytes 0x00, interrupt levels 0x00, interrupt control bytes 0x00, and both DMA entries 0x04.
- R2: Index 0x30 stores bit 0 as the activate flag, which drives dev_active. Bits [7:1] of index 0x30 always read as 0.
- R3: Index 0x31 stores bit 1 (test enable) and bit 0 (pattern select). Bits [7:2] of index 0x31 always read as 0.
- R4: The I/O base of range i (0..7) takes its high byte from index 0x60+2i and its low byte from index 0x61+2i. Both bytes are read/write in full.
- R5: For interrupt entry j (0..1), the level is held in bits [3:0] of index 0x70+2j, and bits [7:4] read 0. The control byte at index 0x71+2j holds bit 1 (polarity, 1 = high) and bit 0 (1 = level, 0 = edge), and bits [7:2] read 0.
- R6: Indices 0x74 and 0x75 each keep bits [2:0] as a DMA channel number. Bits [7:3] read 0, and the value 4 means no channel.
- R7: Any other index reads as 0x00. A write to such an index changes no register.
- R8: A conflict-test hit is a host read that lands in an active window while the test is armed. On a hit, host_hit is 1 in the same cycle, and host_rdata is 0x55 when pattern select is 1 or 0xAA when it is 0.
- R9: While the activate flag is 1, host_hit stays 0 even when test enable is set.
- R10: Range i's window covers addresses base..base+7 and nothing else. A base of 0x0000 opens no window. With test enable at 0 there is never a hit.
- R11: A cfg_rst pulse restores every register to its R1 value on the next clock edge.
- R12: host_rdata is 0x00 whenever host_hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rst | input | 1 | Synchronous configuration reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_idx (combinational) |
| host_rd | input | 1 | Host I/O read cycle |
| host_addr | input | 16 | Host I/O address |
| host_rdata | output | 8 | Conflict-test response byte |
| host_hit | output | 1 | Block drives host_rdata this cycle |
| dev_active | output | 1 | Logical device is active |

## Verification
Random writes to mapped and unmapped indices, each followed by readback, separate stored bits from reserved bits. They also show that a write to one index never disturbs another. Host reads are aimed at the edges of each window: base-1, base, base+7 and base+8. These reads tell a correct eight-port window apart from an off-by-one bound. The same addresses are replayed with test enable off, with the device active, and with each pattern value. This shows that the arming condition and the pattern choice are independent of the address match. A configuration reset issued after random programming shows that the DMA entries return to 4 rather than to 0.

// File: rtl/ldev_pkg.sv
package ldev_pkg;
   typedef struct packed {
      logic en;
      logic pat;
   } rc_t;

   localparam logic [7:0] RC_PAT_ONE  = 8'h55;
   localparam logic [7:0] RC_PAT_ZERO = 8'hAA;
endpackage

// File: rtl/ldev_ctl_regs.sv
module ldev_ctl_regs
   import ldev_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int DATA_W  = 8,
   parameter int IDX_ACT = 'h30,
   parameter int IDX_RC  = 'h31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_hit,
   output logic              act_o,
   output rc_t               rc_o
);
   localparam logic [IDX_W-1:0] A_ACT = IDX_W'(IDX_ACT);
   localparam logic [IDX_W-1:0] A_RC  = IDX_W'(IDX_RC);

   if (IDX_ACT == IDX_RC) begin : g_bad_idx
      $error("activate and range-check indices collide");
   end

   logic act_q;
   rc_t  rc_q;
   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data[DATA_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rc_q  <= '0;
      end else if (cfg_rst) begin
         act_q <= 1'b0;
         rc_q  <= '0;
      end else if (wr_en) begin
         if (wr_idx == A_ACT) act_q <= wr_data[0];
         if (wr_idx == A_RC) begin
            rc_q.en  <= wr_data[1];
            rc_q.pat <= wr_data[0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      rd_hit  = 1'b0;
      if (rd_idx == A_ACT) begin
         rd_hit     = 1'b1;
         rd_data[0] = act_q;
      end else if (rd_idx == A_RC) begin
         rd_hit     = 1'b1;
         rd_data[1] = rc_q.en;
         rd_data[0] = rc_q.pat;
      end
   end

   assign act_o = act_q;
   assign rc_o  = rc_q;

   AST_CFG_CLEARS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rst |=> (!act_o && !rc_o.en && !rc_o.pat)); // R11
   AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rst && !(wr_en && wr_idx == A_ACT)) |=> $stable(act_o)); // R7
endmodule

// File: rtl/ldev_res_regs.sv
module ldev_res_regs #(
   parameter int IDX_W            = 8,
   parameter int DATA_W           = 8,
   parameter int ADDR_W           = 16,
   parameter int N_IO             = 8,
   parameter int N_IRQ            = 2,
   parameter int N_DMA            = 2,
   parameter int IDX_IO           = 'h60,
   parameter int IDX_IRQ          = 'h70,
   parameter int IDX_DMA          = 'h74,
   parameter int LVL_W            = 4,
   parameter int DMA_W            = 3,
   parameter int DMA_NONE         = 4,
   parameter bit IRQ_CTL_WRITABLE = 1'b1,
   parameter logic [1:0] IRQ_CTL_FIXED = 2'b00
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_rst,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_hit,
   output logic [N_IO*ADDR_W-1:0]   io_base_o
);
   localparam int BYTE_PER_BASE = ADDR_W / DATA_W;

   if (ADDR_W != 2*DATA_W) begin : g_bad_w
      $error("base address must be two data bytes");
   end
   if (IDX_IO + 2*N_IO > IDX_IRQ) begin : g_bad_io
      $error("I/O base block overlaps interrupt block");
   end
   if (IDX_IRQ + 2*N_IRQ > IDX_DMA) begin : g_bad_irq
      $error("interrupt block overlaps DMA block");
   end
   if (DMA_NONE >= (1 << DMA_W) || LVL_W > DATA_W) begin : g_bad_fld
      $error("field widths inconsistent");
   end

   logic [DATA_W-1:0] io_hi [N_IO];
   logic [DATA_W-1:0] io_lo [N_IO];
   logic [LVL_W-1:0]  lvl_q [N_IRQ];
   logic [1:0]        ictl  [N_IRQ];
   logic [DMA_W-1:0]  dma_q [N_DMA];

   for (genvar i = 0; i < N_IO; i++) begin : g_io
      localparam logic [IDX_W-1:0] A_HI = IDX_W'(IDX_IO + BYTE_PER_BASE*i);
      localparam logic [IDX_W-1:0] A_LO = IDX_W'(IDX_IO + BYTE_PER_BASE*i + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            io_hi[i] <= '0;
            io_lo[i] <= '0;
         end else if (cfg_rst) begin
            io_hi[i] <= '0;
            io_lo[i] <= '0;
         end else if (wr_en) begin
            if (wr_idx == A_HI) io_hi[i] <= wr_data;
            if (wr_idx == A_LO) io_lo[i] <= wr_data;
         end
      end
      assign io_base_o[i*ADDR_W +: ADDR_W] = {io_hi[i], io_lo[i]};
   end

   for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
      localparam logic [IDX_W-1:0] A_LVL = IDX_W'(IDX_IRQ + 2*j);
      localparam logic [IDX_W-1:0] A_CTL = IDX_W'(IDX_IRQ + 2*j + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          lvl_q[j] <= '0;
         else if (cfg_rst)                    lvl_q[j] <= '0;
         else if (wr_en && wr_idx == A_LVL)   lvl_q[j] <= wr_data[LVL_W-1:0];
      end
      if (IRQ_CTL_WRITABLE) begin : g_ctl_rw
         logic [1:0] ctl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        ctl_q <= '0;
            else if (cfg_rst)                  ctl_q <= '0;
            else if (wr_en && wr_idx == A_CTL) ctl_q <= wr_data[1:0];
         end
         assign ictl[j] = ctl_q;
      end else begin : g_ctl_ro
         assign ictl[j] = IRQ_CTL_FIXED;
      end
   end

   for (genvar k = 0; k < N_DMA; k++) begin : g_dma
      localparam logic [IDX_W-1:0] A_DMA = IDX_W'(IDX_DMA + k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        dma_q[k] <= DMA_W'(DMA_NONE);
         else if (cfg_rst)                  dma_q[k] <= DMA_W'(DMA_NONE);
         else if (wr_en && wr_idx == A_DMA) dma_q[k] <= wr_data[DMA_W-1:0];
      end
      AST_DMA_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_rst |=> (dma_q[k] == DMA_W'(DMA_NONE))); // R11
   end

   always_comb begin
      rd_data = '0;
      rd_hit  = 1'b0;
      for (int i = 0; i < N_IO; i++) begin
         if (rd_idx == IDX_W'(IDX_IO + BYTE_PER_BASE*i)) begin
            rd_hit  = 1'b1;
            rd_data = io_hi[i];
         end
         if (rd_idx == IDX_W'(IDX_IO + BYTE_PER_BASE*i + 1)) begin
            rd_hit  = 1'b1;
            rd_data = io_lo[i];
         end
      end
      for (int j = 0; j < N_IRQ; j++) begin
         if (rd_idx == IDX_W'(IDX_IRQ + 2*j)) begin
            rd_hit  = 1'b1;
            rd_data = DATA_W'(lvl_q[j]);
         end
         if (rd_idx == IDX_W'(IDX_IRQ + 2*j + 1)) begin
            rd_hit  = 1'b1;
            rd_data = DATA_W'(ictl[j]);
         end
      end
      for (int k = 0; k < N_DMA; k++) begin
         if (rd_idx == IDX_W'(IDX_DMA + k)) begin
            rd_hit  = 1'b1;
            rd_data = DATA_W'(dma_q[k]);
         end
      end
   end

   AST_RD_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_data == '0)); // R7
endmodule

// File: rtl/ldev_io_decode.sv
module ldev_io_decode #(
   parameter int ADDR_W    = 16,
   parameter int N_IO      = 8,
   parameter int WIN_PORTS = 8
) (
   input  logic [N_IO*ADDR_W-1:0] io_base,
   input  logic [ADDR_W-1:0]      addr,
   output logic                   hit
);
   if (WIN_PORTS < 1 || N_IO < 1) begin : g_bad
      $error("window and range count must be positive");
   end

   localparam logic [ADDR_W:0] WIN = (ADDR_W+1)'(WIN_PORTS);

   logic [N_IO-1:0] hit_v;
   logic [ADDR_W:0] addr_x;
   assign addr_x = {1'b0, addr};

   for (genvar i = 0; i < N_IO; i++) begin : g_win
      logic [ADDR_W:0] lo_x;
      logic            live;
      assign lo_x     = {1'b0, io_base[i*ADDR_W +: ADDR_W]};
      assign live     = (io_base[i*ADDR_W +: ADDR_W] != '0);
      assign hit_v[i] = live && (addr_x >= lo_x) && (addr_x < lo_x + WIN);
   end

   assign hit = |hit_v;
endmodule

// File: rtl/ldev_cfg_regs.sv
module ldev_cfg_regs
   import ldev_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int N_IO      = 8,
   parameter int N_IRQ     = 2,
   parameter int N_DMA     = 2,
   parameter int WIN_PORTS = 8,
   parameter int IDX_ACT   = 'h30,
   parameter int IDX_RC    = 'h31,
   parameter int IDX_IO    = 'h60,
   parameter int IDX_IRQ   = 'h70,
   parameter int IDX_DMA   = 'h74,
   parameter int DMA_NONE  = 4,
   parameter bit IRQ_CTL_WRITABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_rst,
   input  logic              reg_wr,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_hit,
   output logic              dev_active
);
   if (DATA_W != 8) begin : g_bad_dw
      $error("test patterns need an 8-bit data path");
   end

   logic              act;
   rc_t               rc;
   logic [DATA_W-1:0] ctl_rd, res_rd;
   logic              ctl_hit, res_hit, win_hit;
   logic [N_IO*ADDR_W-1:0] bases;
   logic              unused_res_hit;
   assign unused_res_hit = res_hit;

   ldev_ctl_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .IDX_ACT(IDX_ACT),
                   .IDX_RC(IDX_RC)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_rst(cfg_rst), .wr_en(reg_wr),
      .wr_idx(reg_idx), .wr_data(reg_wdata), .rd_idx(reg_idx),
      .rd_data(ctl_rd), .rd_hit(ctl_hit), .act_o(act), .rc_o(rc));

   ldev_res_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                   .N_IO(N_IO), .N_IRQ(N_IRQ), .N_DMA(N_DMA),
                   .IDX_IO(IDX_IO), .IDX_IRQ(IDX_IRQ), .IDX_DMA(IDX_DMA),
                   .DMA_NONE(DMA_NONE),
                   .IRQ_CTL_WRITABLE(IRQ_CTL_WRITABLE)) u_res (
      .clk(clk), .rst_n(rst_n), .cfg_rst(cfg_rst), .wr_en(reg_wr),
      .wr_idx(reg_idx), .wr_data(reg_wdata), .rd_idx(reg_idx),
      .rd_data(res_rd), .rd_hit(res_hit), .io_base_o(bases));

   ldev_io_decode #(.ADDR_W(ADDR_W), .N_IO(N_IO), .WIN_PORTS(WIN_PORTS)) u_dec (
      .io_base(bases), .addr(host_addr), .hit(win_hit));

   assign reg_rdata  = ctl_hit ? ctl_rd : res_rd;
   assign host_hit   = host_rd && rc.en && !act && win_hit;
   assign host_rdata = host_hit ? (rc.pat ? RC_PAT_ONE : RC_PAT_ZERO) : '0;
   assign dev_active = act;

   AST_HIT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      host_hit |-> !dev_active); // R9
   AST_HIT_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      host_hit |-> host_rd); // R8
   AST_PAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      host_hit |-> (host_rdata == 8'h55 || host_rdata == 8'hAA)); // R8
   AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !host_hit |-> (host_rdata == '0)); // R12
   AST_ACT_RSV: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx == IDX_W'(IDX_ACT)) |-> (reg_rdata[DATA_W-1:1] == '0)); // R2
   AST_RC_RSV: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx == IDX_W'(IDX_RC)) |-> (reg_rdata[DATA_W-1:2] == '0)); // R3
   AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rst |=> !host_hit); // R11
endmodule

// File: tb/sim_ldev_cfg_regs.sv
module sim_ldev_cfg_regs;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_rst = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_idx = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       host_rd = 1'b0;
   logic [15:0] host_addr = 16'h0000;
   logic [7:0] host_rdata;
   logic       host_hit;
   logic       dev_active;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model
   bit         m_act, m_en, m_pat;
   logic [15:0] m_io [8];
   logic [3:0] m_lvl [2];
   logic [1:0] m_ctl [2];
   logic [2:0] m_dma [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   ldev_cfg_regs u0 (
      .clk(clk), .rst_n(rst_n), .cfg_rst(cfg_rst), .reg_wr(reg_wr),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata),
      .host_hit(host_hit), .dev_active(dev_active));

   function automatic void mdl_reset();
      m_act = 0; m_en = 0; m_pat = 0;
      for (int i = 0; i < 8; i++) m_io[i] = '0;
      for (int j = 0; j < 2; j++) begin m_lvl[j] = '0; m_ctl[j] = '0; m_dma[j] = 3'd4; end
   endfunction

   function automatic void mdl_wr(input logic [7:0] idx, input logic [7:0] d);
      if (idx == 8'h30) m_act = d[0];
      else if (idx == 8'h31) begin m_en = d[1]; m_pat = d[0]; end
      else if (idx >= 8'h60 && idx <= 8'h6F) begin
         if (idx[0]) m_io[(idx - 8'h60) >> 1][7:0] = d;
         else        m_io[(idx - 8'h60) >> 1][15:8] = d;
      end
      else if (idx == 8'h70) m_lvl[0] = d[3:0];
      else if (idx == 8'h71) m_ctl[0] = d[1:0];
      else if (idx == 8'h72) m_lvl[1] = d[3:0];
      else if (idx == 8'h73) m_ctl[1] = d[1:0];
      else if (idx == 8'h74) m_dma[0] = d[2:0];
      else if (idx == 8'h75) m_dma[1] = d[2:0];
   endfunction

   function automatic logic [7:0] exp_reg(input logic [7:0] idx);
      if (idx == 8'h30) return {7'b0, m_act};
      if (idx == 8'h31) return {6'b0, m_en, m_pat};
      if (idx >= 8'h60 && idx <= 8'h6F)
         return idx[0] ? m_io[(idx - 8'h60) >> 1][7:0] : m_io[(idx - 8'h60) >> 1][15:8];
      if (idx == 8'h70) return {4'b0, m_lvl[0]};
      if (idx == 8'h71) return {6'b0, m_ctl[0]};
      if (idx == 8'h72) return {4'b0, m_lvl[1]};
      if (idx == 8'h73) return {6'b0, m_ctl[1]};
      if (idx == 8'h74) return {5'b0, m_dma[0]};
      if (idx == 8'h75) return {5'b0, m_dma[1]};
      return 8'h00;
   endfunction

   function automatic string tag_of(input logic [7:0] idx);
      if (idx == 8'h30) return "R2";
      if (idx == 8'h31) return "R3";
      if (idx >= 8'h60 && idx <= 8'h6F) return "R4";
      if (idx >= 8'h70 && idx <= 8'h73) return "R5";
      if (idx == 8'h74 || idx == 8'h75) return "R6";
      return "R7";
   endfunction

   function automatic bit exp_hit(input logic [15:0] a);
      bit w = 0;
      for (int i = 0; i < 8; i++)
         if (m_io[i] != 0 && int'(a) >= int'(m_io[i]) && int'(a) < int'(m_io[i]) + 8) w = 1;
      return w && m_en && !m_act;
   endfunction

   task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] idx, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      mdl_wr(idx, d);
   endtask

   task automatic rd_chk(input logic [7:0] idx, input string tag);
      @(negedge clk);
      reg_idx = idx;
      #1;
      cmp(tag, {8'h00, reg_rdata}, {8'h00, exp_reg(idx)});
   endtask

   task automatic host_chk(input logic [15:0] a, input string tag);
      logic [7:0] ed;
      @(negedge clk);
      host_rd = 1; host_addr = a;
      #1;
      ed = exp_hit(a) ? (m_pat ? 8'h55 : 8'hAA) : 8'h00;
      cmp(tag, {15'b0, host_hit}, {15'b0, exp_hit(a)});
      cmp(tag, {8'h00, host_rdata}, {8'h00, ed});
      host_rd = 0;
   endtask

   task automatic read_all(input string tag);
      for (int x = 8'h30; x <= 8'h31; x++) rd_chk(8'(x), tag);
      for (int x = 8'h60; x <= 8'h75; x++) rd_chk(8'(x), tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      mdl_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset values
      read_all("R1");
      cmp("R2", {15'b0, dev_active}, 16'h0);

      // R2 / R3 reserved bits
      wr(8'h30, 8'hFF); rd_chk(8'h30, "R2");
      @(negedge clk); cmp("R2", {15'b0, dev_active}, 16'h1);
      wr(8'h30, 8'hFE); rd_chk(8'h30, "R2");
      wr(8'h31, 8'hFF); rd_chk(8'h31, "R3");
      wr(8'h31, 8'hFC); rd_chk(8'h31, "R3");

      // R4 bytes of range 0 and 7, R5, R6
      wr(8'h60, 8'h02); wr(8'h61, 8'h20);
      wr(8'h6E, 8'hFF); wr(8'h6F, 8'hF8);
      rd_chk(8'h60, "R4"); rd_chk(8'h61, "R4"); rd_chk(8'h6E, "R4"); rd_chk(8'h6F, "R4");
      wr(8'h70, 8'hFB); wr(8'h71, 8'hFF); wr(8'h73, 8'hFE);
      rd_chk(8'h70, "R5"); rd_chk(8'h71, "R5"); rd_chk(8'h73, "R5");
      wr(8'h74, 8'hF9); wr(8'h75, 8'h02);
      rd_chk(8'h74, "R6"); rd_chk(8'h75, "R6");

      // R10 test disabled: no hit
      host_chk(16'h0220, "R10");
      host_chk(16'h0223, "R12");
      // R8 armed, both patterns, window edges R10
      wr(8'h31, 8'h03);
      host_chk(16'h021F, "R10");
      host_chk(16'h0220, "R8");
      host_chk(16'h0227, "R8");
      host_chk(16'h0228, "R10");
      host_chk(16'hFFF8, "R8");
      host_chk(16'hFFFF, "R8");
      host_chk(16'h0003, "R10");
      wr(8'h31, 8'h02);
      host_chk(16'h0224, "R8");
      host_chk(16'h0000, "R10");
      // R9 active suppresses
      wr(8'h30, 8'h01);
      host_chk(16'h0224, "R9");
      host_chk(16'hFFFA, "R9");
      wr(8'h30, 8'h00);
      host_chk(16'h0224, "R8");

      // R7 unmapped indices
      wr(8'h20, 8'hFF); wr(8'h40, 8'h5A); wr(8'h76, 8'h33); wr(8'hFF, 8'h01); wr(8'h32, 8'h03);
      rd_chk(8'h20, "R7"); rd_chk(8'h40, "R7"); rd_chk(8'h76, "R7"); rd_chk(8'hFF, "R7"); rd_chk(8'h32, "R7");
      read_all("R7");

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         int sel;
         logic [7:0] idx;
         sel = $urandom_range(0, 9);
         if (sel < 5)       idx = 8'($urandom_range(8'h60, 8'h75));
         else if (sel == 5) idx = 8'h30;
         else if (sel == 6) idx = 8'h31;
         else               idx = 8'($urandom_range(0, 255));
         wr(idx, 8'($urandom));
         rd_chk(idx, tag_of(idx));
         rd_chk(8'($urandom_range(8'h60, 8'h75)), "R4");
         if ($urandom_range(0, 1) == 1) begin
            int r;
            logic [15:0] a;
            r = $urandom_range(0, 7);
            a = m_io[r] + 16'($urandom_range(0, 11)) - 16'd2;
            host_chk(a, m_act ? "R9" : (m_en ? "R8" : "R10"));
         end
      end

      // R11 configuration reset
      wr(8'h31, 8'h03); wr(8'h62, 8'h03); wr(8'h63, 8'h00); wr(8'h74, 8'h01);
      @(negedge clk); cfg_rst = 1;
      @(negedge clk); cfg_rst = 0;
      mdl_reset();
      read_all("R11");
      cmp("R11", {15'b0, dev_active}, 16'h0);
      host_chk(16'h0300, "R11");

      finish_run();
   end
endmodule